// File: doc/BRIEF.md
# Sound Coprocessor Banked Window Address Decoder

This block sits between a small sound coprocessor with a 16-bit address space and the rest of the chip. Each coprocessor access is sorted into one of five regions: local work RAM, the FM synthesizer port, the PSG port, the window bank register, or a 32 KB window that reaches into the 24-bit main bus. Local regions get a one-cycle chip select. Window accesses raise a main-bus request and hold the coprocessor until the bus acknowledges. The sound chips and main-bus arbitration are outside this block.

The window base is a 9-bit register that is filled serially. Each write to the bank location shifts the register right by one place and puts bit 0 of the written byte into its top bit. After nine writes the register holds the nine bits written, with the first write at bit 0. The register's value becomes address bits 23..15 of every window access. A 16-bit coprocessor access is split into two byte accesses: the low lane goes to the given address, then the high lane goes to the address plus one, wrapping within 16 bits.

The sequencer has four states. The transitions are:
- IDLE to ISSUE when a read or write strobe is seen; the address, data, width and direction are latched at that point.
- ISSUE to WAIT when the current byte falls in the window.
- ISSUE to ISSUE, with the high lane selected, after the low lane of a local 16-bit access.
- ISSUE to DONE after the last local byte.
- WAIT to ISSUE, or WAIT to DONE, on the acknowledge, following the same lane rule.
- DONE to IDLE always.

Top module: `snd_addr_decoder`

## Requirements
- R1: Byte addresses 0x0000 to 0x3FFF assert `ram_cs` for one cycle with `loc_addr` equal to address bits 12..0, so the RAM is mirrored every 0x2000. A read returns `ram_rdata` in that lane.
- R2: Byte addresses 0x4000 to 0x5FFF (bits 15..13 equal to 3'b010) assert `fm_cs` for one cycle with `loc_addr` equal to address bits 12..0. A read returns `fm_rdata`.
- R3: A write to an address whose value ANDed with 0xFFF9 equals 0x7F11 (0x7F11, 0x7F13, 0x7F15, 0x7F17) asserts `psg_cs` with `loc_we` high. A read of those addresses raises no select and returns 0xFF.
- R4: A write to any address with high byte 0x60 sets the bank to {data bit 0, bank bits 8..1}. The bank is 0 after reset and changes on no other event. It is seen as `mb_addr[23:15]`.
- R5: Byte addresses 0x8000 and above drive `mb_addr` = bank * 0x8000 + (address & 0x7FFF), with `mb_we` giving the direction and `mb_wdata` the lane byte.
- R6: `mb_req` stays high, with `mb_addr`, `mb_we` and `mb_wdata` stable, until the first cycle in which `mb_ack` is high, and for no longer. `cp_done` is never high while `mb_req` is high. A read takes `mb_rdata` in the acknowledge cycle.
- R7: Other addresses (0x6000 to 0x7FFF outside the bank and PSG locations, and reads of the bank location) raise no select and leave the bank unchanged. Reads there return 0xFF.
- R8: With `cp_wide` high, the low lane (`cp_wdata[7:0]`, `cp_rdata[7:0]`) is accessed at the address first. The high lane is then accessed at the address plus one, modulo 0x10000.
- R9: `cp_done` is a one-cycle pulse. Count clock edges from the edge that samples the strobe in IDLE: a local byte adds one edge, a window byte adds 2 plus the number of cycles `mb_ack` was held low. `cp_done` rises one edge after the last byte.
- R10: At most one of `ram_cs`, `fm_cs`, `psg_cs` and `mb_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cp_addr | input | 16 | Coprocessor address, held until `cp_done` |
| cp_wdata | input | 16 | Write data; low lane is bits 7..0 |
| cp_rd | input | 1 | Read strobe, held until `cp_done` |
| cp_wr | input | 1 | Write strobe, held until `cp_done`; has priority over `cp_rd` |
| cp_wide | input | 1 | High for a 16-bit access |
| cp_rdata | output | 16 | Read data, valid while `cp_done` is high |
| cp_done | output | 1 | Access complete pulse |
| loc_addr | output | 13 | Address for the local RAM and FM port |
| loc_wdata | output | 8 | Byte written to a local port |
| loc_we | output | 1 | Direction of the local access |
| ram_cs | output | 1 | Local RAM select |
| ram_rdata | input | 8 | Local RAM read byte |
| fm_cs | output | 1 | FM synthesizer port select |
| fm_rdata | input | 8 | FM port read byte |
| psg_cs | output | 1 | PSG write select |
| mb_req | output | 1 | Main-bus request |
| mb_addr | output | 24 | Main-bus byte address |
| mb_we | output | 1 | Main-bus write enable |
| mb_wdata | output | 8 | Main-bus write byte |
| mb_rdata | input | 8 | Main-bus read byte |
| mb_ack | input | 1 | Main-bus acknowledge |

## Verification
A corrupted bank register does not show up at once. It only appears on the next window access, as wrong upper bits of `mb_addr`, so every window byte is compared against a shift model of all earlier bank writes. A stuck or mis-sequenced state shows up within the same access. Symptoms are a missing or repeated select, a lane landing on the wrong address, or `cp_done` arriving a cycle early or late against the cost computed per byte. The sweep covers every region boundary and both lane orders.

// File: rtl/snd_dec_pkg.sv
package snd_dec_pkg;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_RAM,
        RG_FM,
        RG_PSG,
        RG_BANK,
        RG_WIN
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/snd_region_decode.sv
module snd_region_decode
    import snd_dec_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    output region_e           region
);
    localparam logic [ADDR_W-1:0] PSG_MASK  = ADDR_W'('hFFF9);
    localparam logic [ADDR_W-1:0] PSG_MATCH = ADDR_W'('h7F11);
    localparam logic [7:0]        BANK_HI   = 8'h60;

    logic in_win, in_fm, in_ram, in_psg, in_bank;

    always_comb begin
        in_win  = addr[ADDR_W-1];
        in_fm   = (addr[ADDR_W-1 -: 3] == 3'b010);
        in_ram  = (addr[ADDR_W-1 -: 2] == 2'b00);
        in_psg  = ((addr & PSG_MASK) == PSG_MATCH);
        in_bank = (addr[ADDR_W-1 -: 8] == BANK_HI);
    end

    always_comb begin
        if (in_win)
            region = RG_WIN;
        else if (in_fm)
            region = RG_FM;
        else if (in_ram)
            region = RG_RAM;
        else if (in_psg)
            region = is_write ? RG_PSG : RG_NONE;
        else if (in_bank)
            region = is_write ? RG_BANK : RG_NONE;
        else
            region = RG_NONE;
    end

endmodule

// File: rtl/snd_bank_shift.sv
module snd_bank_shift #(
    parameter int BANK_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [BANK_W-1:0] bank
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank <= '0;
        else if (shift_en)
            bank <= {bit_in, bank[BANK_W-1:1]};
    end

endmodule

// File: rtl/snd_byte_seq.sv
module snd_byte_seq
    import snd_dec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     cp_addr,
    input  logic [2*DATA_W-1:0]   cp_wdata,
    input  logic                  cp_rd,
    input  logic                  cp_wr,
    input  logic                  cp_wide,
    input  region_e               region,
    input  logic [DATA_W-1:0]     ram_rdata,
    input  logic [DATA_W-1:0]     fm_rdata,
    input  logic [DATA_W-1:0]     mb_rdata,
    input  logic                  mb_ack,
    output logic [ADDR_W-1:0]     cur_addr,
    output logic [DATA_W-1:0]     cur_wdata,
    output logic                  cur_we,
    output logic                  ram_cs,
    output logic                  fm_cs,
    output logic                  psg_cs,
    output logic                  bank_shift,
    output logic                  mb_req,
    output logic                  cp_done,
    output logic [2*DATA_W-1:0]   cp_rdata
);
    localparam logic [DATA_W-1:0] OPEN_BUS = '1;

    seq_state_e state_q, state_d;

    logic [ADDR_W-1:0]   base_q;
    logic [2*DATA_W-1:0] wdata_q;
    logic [2*DATA_W-1:0] rdata_q;
    logic                we_q;
    logic                wide_q;
    logic                hi_q;

    logic                byte_end;
    logic                more_lanes;
    logic [DATA_W-1:0]   local_byte;

    assign cur_addr  = base_q + ADDR_W'(hi_q);
    assign cur_wdata = hi_q ? wdata_q[2*DATA_W-1:DATA_W] : wdata_q[DATA_W-1:0];
    assign cur_we    = we_q;
    assign cp_rdata  = rdata_q;

    assign more_lanes = wide_q && !hi_q;

    always_comb begin
        unique case (region)
            RG_RAM:  local_byte = ram_rdata;
            RG_FM:   local_byte = fm_rdata;
            default: local_byte = OPEN_BUS;
        endcase
    end

    // the current byte finishes this cycle
    always_comb begin
        byte_end = 1'b0;
        unique case (state_q)
            ST_ISSUE: byte_end = (region != RG_WIN);
            ST_WAIT:  byte_end = mb_ack;
            default:  byte_end = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cp_rd || cp_wr) state_d = ST_ISSUE;
            ST_ISSUE: begin
                if (region == RG_WIN)
                    state_d = ST_WAIT;
                else
                    state_d = more_lanes ? ST_ISSUE : ST_DONE;
            end
            ST_WAIT:  if (mb_ack) state_d = more_lanes ? ST_ISSUE : ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            we_q    <= 1'b0;
            wide_q  <= 1'b0;
            hi_q    <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && (cp_rd || cp_wr)) begin
                base_q  <= cp_addr;
                wdata_q <= cp_wdata;
                we_q    <= cp_wr;
                wide_q  <= cp_wide;
                hi_q    <= 1'b0;
            end
            if (byte_end) begin
                if (hi_q)
                    rdata_q[2*DATA_W-1:DATA_W] <= (state_q == ST_WAIT) ? mb_rdata : local_byte;
                else
                    rdata_q[DATA_W-1:0] <= (state_q == ST_WAIT) ? mb_rdata : local_byte;
                if (more_lanes)
                    hi_q <= 1'b1;
            end
        end
    end

    always_comb begin
        ram_cs     = 1'b0;
        fm_cs      = 1'b0;
        psg_cs     = 1'b0;
        bank_shift = 1'b0;
        mb_req     = 1'b0;
        cp_done    = 1'b0;
        unique case (state_q)
            ST_ISSUE: begin
                ram_cs     = (region == RG_RAM);
                fm_cs      = (region == RG_FM);
                psg_cs     = (region == RG_PSG);
                bank_shift = (region == RG_BANK);
            end
            ST_WAIT:  mb_req  = 1'b1;
            ST_DONE:  cp_done = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/snd_addr_decoder.sv
module snd_addr_decoder
    import snd_dec_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int BANK_W  = 9,
    parameter int WIN_W   = 15,
    parameter int LOC_W   = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cp_addr,
    input  logic [2*DATA_W-1:0]  cp_wdata,
    input  logic                 cp_rd,
    input  logic                 cp_wr,
    input  logic                 cp_wide,
    output logic [2*DATA_W-1:0]  cp_rdata,
    output logic                 cp_done,
    output logic [LOC_W-1:0]     loc_addr,
    output logic [DATA_W-1:0]    loc_wdata,
    output logic                 loc_we,
    output logic                 ram_cs,
    input  logic [DATA_W-1:0]    ram_rdata,
    output logic                 fm_cs,
    input  logic [DATA_W-1:0]    fm_rdata,
    output logic                 psg_cs,
    output logic                 mb_req,
    output logic [BANK_W+WIN_W-1:0] mb_addr,
    output logic                 mb_we,
    output logic [DATA_W-1:0]    mb_wdata,
    input  logic [DATA_W-1:0]    mb_rdata,
    input  logic                 mb_ack
);
    region_e           region;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    logic              cur_we;
    logic              bank_shift;
    logic [BANK_W-1:0] bank_q;

    snd_region_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr     (cur_addr),
        .is_write (cur_we),
        .region   (region)
    );

    snd_bank_shift #(.BANK_W(BANK_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bank_shift),
        .bit_in   (cur_wdata[0]),
        .bank     (bank_q)
    );

    snd_byte_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cp_addr    (cp_addr),
        .cp_wdata   (cp_wdata),
        .cp_rd      (cp_rd),
        .cp_wr      (cp_wr),
        .cp_wide    (cp_wide),
        .region     (region),
        .ram_rdata  (ram_rdata),
        .fm_rdata   (fm_rdata),
        .mb_rdata   (mb_rdata),
        .mb_ack     (mb_ack),
        .cur_addr   (cur_addr),
        .cur_wdata  (cur_wdata),
        .cur_we     (cur_we),
        .ram_cs     (ram_cs),
        .fm_cs      (fm_cs),
        .psg_cs     (psg_cs),
        .bank_shift (bank_shift),
        .mb_req     (mb_req),
        .cp_done    (cp_done),
        .cp_rdata   (cp_rdata)
    );

    assign loc_addr  = cur_addr[LOC_W-1:0];
    assign loc_wdata = cur_wdata;
    assign loc_we    = cur_we;
    assign mb_addr   = {bank_q, cur_addr[WIN_W-1:0]};
    assign mb_we     = cur_we;
    assign mb_wdata  = cur_wdata;

endmodule

// File: rtl/snd_addr_decoder_chk.sv
module snd_addr_decoder_chk #(
    parameter int BANK_W = 9,
    parameter int AW     = 24,
    parameter int DW     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ram_cs,
    input logic              fm_cs,
    input logic              psg_cs,
    input logic              loc_we,
    input logic [DW-1:0]     loc_wdata,
    input logic              mb_req,
    input logic              mb_ack,
    input logic [AW-1:0]     mb_addr,
    input logic              mb_we,
    input logic [DW-1:0]     mb_wdata,
    input logic              cp_done,
    input logic              bank_shift,
    input logic [BANK_W-1:0] bank
);
    // R10
    a_r10_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_cs, fm_cs, psg_cs, mb_req}));

    // R3
    a_r3_psg_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        psg_cs |-> loc_we);

    // R6
    a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_req && !mb_ack) |=> (mb_req && $stable(mb_addr) && $stable(mb_we) && $stable(mb_wdata)));

    // R6
    a_r6_release_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_req && mb_ack) |=> !mb_req);

    // R6
    a_r6_no_done_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        mb_req |-> !cp_done);

    // R9
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cp_done |=> !cp_done);

    // R4
    a_r4_bank_shift: assert property (@(posedge clk) disable iff (!rst_n)
        bank_shift |=> (bank == {$past(loc_wdata[0]), $past(bank[BANK_W-1:1])}));

    // R4
    a_r4_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_shift |=> $stable(bank));

endmodule

bind snd_addr_decoder snd_addr_decoder_chk #(
    .BANK_W (BANK_W),
    .AW     (BANK_W + WIN_W),
    .DW     (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ram_cs     (ram_cs),
    .fm_cs      (fm_cs),
    .psg_cs     (psg_cs),
    .loc_we     (loc_we),
    .loc_wdata  (loc_wdata),
    .mb_req     (mb_req),
    .mb_ack     (mb_ack),
    .mb_addr    (mb_addr),
    .mb_we      (mb_we),
    .mb_wdata   (mb_wdata),
    .cp_done    (cp_done),
    .bank_shift (bank_shift),
    .bank       (bank_q)
);

// File: tb/snd_addr_decoder_test.sv
module snd_addr_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cp_addr = '0;
    logic [15:0] cp_wdata = '0;
    logic        cp_rd = 1'b0;
    logic        cp_wr = 1'b0;
    logic        cp_wide = 1'b0;
    logic [15:0] cp_rdata;
    logic        cp_done;
    logic [12:0] loc_addr;
    logic [7:0]  loc_wdata;
    logic        loc_we;
    logic        ram_cs;
    logic [7:0]  ram_rdata;
    logic        fm_cs;
    logic [7:0]  fm_rdata;
    logic        psg_cs;
    logic        mb_req;
    logic [23:0] mb_addr;
    logic        mb_we;
    logic [7:0]  mb_wdata;
    logic [7:0]  mb_rdata;
    logic        mb_ack = 1'b0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [8:0] bank_m = '0;

    localparam int K_NONE = 0, K_RAM = 1, K_FM = 2, K_PSG = 3, K_WIN = 4;

    always #2 clk = ~clk;

    function automatic logic [7:0] f_ram(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b101};
    endfunction
    function automatic logic [7:0] f_fm(input logic [12:0] a);
        return {a[1:0], 6'h2B} ^ a[9:2];
    endfunction
    function automatic logic [7:0] f_mb(input logic [23:0] a);
        return a[7:0] ^ a[23:16] ^ {a[15:14], 6'h11};
    endfunction

    assign ram_rdata = f_ram(loc_addr);
    assign fm_rdata  = f_fm(loc_addr);
    assign mb_rdata  = f_mb(mb_addr);

    snd_addr_decoder uut (
        .clk(clk), .rst_n(rst_n), .cp_addr(cp_addr), .cp_wdata(cp_wdata),
        .cp_rd(cp_rd), .cp_wr(cp_wr), .cp_wide(cp_wide), .cp_rdata(cp_rdata),
        .cp_done(cp_done), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
        .loc_we(loc_we), .ram_cs(ram_cs), .ram_rdata(ram_rdata), .fm_cs(fm_cs),
        .fm_rdata(fm_rdata), .psg_cs(psg_cs), .mb_req(mb_req), .mb_addr(mb_addr),
        .mb_we(mb_we), .mb_wdata(mb_wdata), .mb_rdata(mb_rdata), .mb_ack(mb_ack)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int kind_of(input logic [15:0] a, input bit wr);
        if (a[15]) return K_WIN;
        if (a[15:13] == 3'b010) return K_FM;
        if (a[15:14] == 2'b00) return K_RAM;
        if ((a & 16'hFFF9) == 16'h7F11) return wr ? K_PSG : K_NONE;
        return K_NONE;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // one coprocessor access with full port-level checking
    task automatic access(input logic [15:0] a, input bit wr, input bit wide,
                          input logic [15:0] wd, input int dly);
        int         nb;
        int         exp_k[2];
        logic [23:0] exp_ad[2];
        logic [7:0] exp_rd[2];
        logic [7:0] exp_wd[2];
        int         exp_cost;
        int         ev_k[2];
        logic [23:0] ev_ad[2];
        logic [7:0] ev_wd[2];
        logic       ev_we[2];
        int         ev_wait[2];
        int         nev;
        int         iter;
        int         wcnt;
        bit         done_seen;
        logic [15:0] got_rd;
        nb = wide ? 2 : 1;
        exp_cost = 1;
        nev = 0;
        for (int b = 0; b < nb; b++) begin
            logic [15:0] ba;
            ba = a + 16'(b);
            exp_wd[b] = b ? wd[15:8] : wd[7:0];
            exp_k[b] = kind_of(ba, wr);
            exp_rd[b] = 8'hFF;
            exp_ad[b] = '0;
            case (exp_k[b])
                K_RAM: begin exp_ad[b] = {11'd0, ba[12:0]}; exp_rd[b] = f_ram(ba[12:0]); end
                K_FM:  begin exp_ad[b] = {11'd0, ba[12:0]}; exp_rd[b] = f_fm(ba[12:0]); end
                K_PSG: exp_ad[b] = {11'd0, ba[12:0]};
                K_WIN: begin exp_ad[b] = {bank_m, ba[14:0]}; exp_rd[b] = f_mb({bank_m, ba[14:0]}); end
                default: ;
            endcase
            if (wr && ba[15:8] == 8'h60) bank_m = {exp_wd[b][0], bank_m[8:1]};
            exp_cost += (exp_k[b] == K_WIN) ? (2 + dly) : 1;
        end
        @(negedge clk);
        cp_addr = a; cp_wdata = wd; cp_wide = wide; cp_wr = wr; cp_rd = !wr;
        iter = 0; wcnt = 0; done_seen = 0; got_rd = '0;
        while (!done_seen && iter < 50) begin
            @(negedge clk);
            iter++;
            if (mb_ack) mb_ack = 1'b0;
            if (ram_cs || fm_cs || psg_cs) begin
                if (nev < 2) begin
                    ev_k[nev] = ram_cs ? K_RAM : (fm_cs ? K_FM : K_PSG);
                    ev_ad[nev] = {11'd0, loc_addr};
                    ev_wd[nev] = loc_wdata; ev_we[nev] = loc_we; ev_wait[nev] = 0;
                end
                nev++;
            end
            if (mb_req) begin
                wcnt++;
                if (wcnt > dly) begin
                    mb_ack = 1'b1;
                    if (nev < 2) begin
                        ev_k[nev] = K_WIN; ev_ad[nev] = mb_addr;
                        ev_wd[nev] = mb_wdata; ev_we[nev] = mb_we; ev_wait[nev] = wcnt;
                    end
                    nev++;
                    wcnt = 0;
                end
            end
            if (cp_done) begin
                done_seen = 1;
                got_rd = cp_rdata;
            end
        end
        cp_rd = 1'b0; cp_wr = 1'b0;
        check(done_seen, "R9", "done reached", done_seen, 1);
        // R9: latency from strobe sample to done
        check(iter == exp_cost, "R9", "done latency", iter, exp_cost);
        begin
            int ne;
            int j;
            ne = 0;
            for (int b = 0; b < nb; b++) if (exp_k[b] != K_NONE) ne++;
            // R7/R10: only mapped bytes produce a select event, one each
            check(nev == ne, "R7", "select event count", nev, ne);
            j = 0;
            for (int b = 0; b < nb; b++) begin
                if (exp_k[b] != K_NONE && j < nev && j < 2) begin
                    string rq;
                    rq = (exp_k[b] == K_RAM) ? "R1" : (exp_k[b] == K_FM) ? "R2" :
                         (exp_k[b] == K_PSG) ? "R3" : "R5";
                    check(ev_k[j] == exp_k[b], rq, "region kind", ev_k[j], exp_k[b]);
                    check(ev_ad[j] == exp_ad[b], wide ? "R8" : rq, "byte address", ev_ad[j], exp_ad[b]);
                    check(ev_we[j] == wr, rq, "direction", ev_we[j], wr);
                    if (wr) check(ev_wd[j] == exp_wd[b], "R8", "lane write data", ev_wd[j], exp_wd[b]);
                    // R6: request held for exactly the wait count
                    if (exp_k[b] == K_WIN) check(ev_wait[j] == dly + 1, "R6", "request cycles", ev_wait[j], dly + 1);
                    j++;
                end
            end
        end
        if (!wr) begin
            check(got_rd[7:0] == exp_rd[0], "R8", "low lane read", got_rd[7:0], exp_rd[0]);
            if (wide) check(got_rd[15:8] == exp_rd[1], "R8", "high lane read", got_rd[15:8], exp_rd[1]);
        end
    endtask

    initial begin
        logic [15:0] corner [22];
        corner = '{16'h0000, 16'h1FFF, 16'h2000, 16'h3FFF, 16'h4000, 16'h5FFF,
                   16'h6000, 16'h60FF, 16'h6100, 16'h7F10, 16'h7F11, 16'h7F13,
                   16'h7F15, 16'h7F16, 16'h7F17, 16'h7F19, 16'h7FFF, 16'h8000,
                   16'hBFFF, 16'hC123, 16'hFFFF, 16'h6F11};
        repeat (3) @(negedge clk);
        // reset state
        check(!cp_done && !ram_cs && !fm_cs && !psg_cs && !mb_req, "R9", "outputs idle in reset",
              {cp_done, ram_cs, fm_cs, psg_cs, mb_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mb_req && !cp_done, "R6", "idle after reset", {mb_req, cp_done}, 0);
        // R4: bank is zero after reset, seen through a window read
        access(16'h8004, 1'b0, 1'b0, 16'h0000, 0);
        // R4: load a known pattern with nine serial writes
        for (int k = 0; k < 9; k++) access(16'h6000 + 16'(k * 7), 1'b1, 1'b0, {8'h00, 7'h3A, 1'(9'h15B >> k)}, 1);
        access(16'h8000, 1'b0, 1'b0, 16'h0000, 2);
        access(16'hFFFE, 1'b1, 1'b1, 16'hBEEF, 3);
        // R7: bank read and unmapped writes leave the bank alone
        access(16'h6000, 1'b0, 1'b0, 16'h0000, 0);
        access(16'h7000, 1'b1, 1'b0, 16'h00FF, 0);
        access(16'h9234, 1'b0, 1'b1, 16'h0000, 1);
        // corners, every width and direction
        for (int c = 0; c < 22; c++)
            for (int m = 0; m < 4; m++)
                access(corner[c], m[0], m[1], 16'hA55A ^ 16'(c * 37), (c + m) % 4);
        // address sweep
        for (int i = 0; i < 400; i++)
            for (int m = 0; m < 4; m++)
                access(16'(i * 16'h00A3 + i * i * 13), m[0], m[1], 16'(i * 16'h3B1 + m), (i + m) % 4);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule